// File: doc/BRIEF.md
# Audio Controller Control Port with Configuration RAM Download

This block is the host-facing control window of an audio controller. Software sees eight byte-wide I/O offsets. One pair of offsets forms an index/data window onto a bank of sixteen indirect control registers. Writes to that bank are masked per register, and some registers are read-only. Another pair of offsets drives a byte-serial loader that fills a local configuration RAM.

The loader offset has two roles. While the loader is idle it takes single-byte commands: hardware-configuration update, Plug and Play enable clear, and key-detect disable. After the start command it takes the low address byte, then the high address byte. After that it acts as a streaming window: every write stores a byte and every read fetches a byte, and each access advances the address by one. A write of one of two close codes to a separate offset ends the sequence and returns the loader to its idle phase. Side effects on other logic leave the block as single-cycle pulses.

Top module: `audio_ctl_port`

## Requirements
- R1: After reset, offset 1 reads 0x80 and all other direct offsets read 0x00. Indirect register 1 reads the CHIP_ID parameter, and every other indirect register reads 0x00. `pnp_enable_o` is 1 and all pulse outputs are 0.
- R2: Reading a direct offset returns the last value written to it, with three exceptions. Offset 3 keeps only bits [3:0] and reads bits [7:4] as zero. Writes to offset 7 are ignored, so it stays 0x00. Offsets 4 and 5 behave as described in R3 and R7.
- R3: The low 4 bits of offset 3 select the indirect register that offset 4 reads and writes. Writes are masked as follows: index 3 with 0xE0, index 4 with 0xF0, index 5 with 0xFE, and index 8 with 0x0F. Indices 2 and 6 store the whole byte. Index 1 is read-only. Writes to indices 7 and 9 to 15 are discarded.
- R4: A write to indirect index 0 with bit 7 set raises `codec_reset_o` for one cycle, in the cycle after the write. Index 0 always reads 0x00 after any write.
- R5: In the command phase, a write to offset 5 is a command. 0x5A pulses `hwcfg_update_o`. 0x55 pulses `hwcfg_update_o` and drives `pnp_enable_o` to 0 until the next reset. 0x56 pulses `key_disable_o`. Any other value except 0xAA has no effect beyond being stored in offset 5.
- R6: In the command phase, a write of 0xAA to offset 5 starts a download. The next write to offset 5 sets the low address byte and the one after sets the high address byte. Each later write stores its byte at the current address and then adds one to the address.
- R7: In the data phase, a read of offset 5 returns the RAM byte at the current address and then adds one to the address. In any other phase, a read of offset 5 returns the last byte written to offset 5.
- R8: A write of 0x00 or 0x40 to offset 6 returns the loader to the command phase and pulses `dl_done_o` in the next cycle. Any other value leaves the phase unchanged and gives no pulse.
- R9: The 16-bit download address is taken modulo RAM_DEPTH, which must be a power of two. Address bits above log2(RAM_DEPTH) are dropped, and increments wrap from RAM_DEPTH-1 to 0.
- R10: While a download is in progress, the command codes 0x55, 0x56, 0x5A and 0xAA written to offset 5 are treated as address or data bytes and raise no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Direct register offset |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe, one cycle per byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the offset on `bus_addr` (combinational) |
| codec_reset_o | output | 1 | One-cycle codec reset pulse |
| hwcfg_update_o | output | 1 | One-cycle hardware-configuration update pulse |
| key_disable_o | output | 1 | One-cycle key-detect disable pulse |
| dl_done_o | output | 1 | One-cycle download-complete pulse |
| pnp_enable_o | output | 1 | Plug and Play enable flag, cleared by command 0x55 |

## Verification
The assertions check the pulse outputs on every cycle. Each pulse must be traced back to the bus write that caused it in the previous cycle. A valid close code must always produce the done pulse, and the Plug and Play flag must stay low once it has fallen. The loader's address sequencing cannot be seen at the ports in a single cycle, so only the bench scenarios can show it. These scenarios cover the storage order, read post-increment, wraparound at the RAM depth, command codes passing through as data, and the ignored close values.

// File: rtl/ctlp_pkg.sv
package ctlp_pkg;

    typedef enum logic [1:0] {
        PH_CMD  = 2'd0,
        PH_ALO  = 2'd1,
        PH_AHI  = 2'd2,
        PH_DATA = 2'd3
    } dl_phase_e;

    localparam logic [2:0] OFS_LINK  = 3'd1;
    localparam logic [2:0] OFS_IDX   = 3'd3;
    localparam logic [2:0] OFS_IDAT  = 3'd4;
    localparam logic [2:0] OFS_DLPRT = 3'd5;
    localparam logic [2:0] OFS_DLEND = 3'd6;
    localparam logic [2:0] OFS_STAT  = 3'd7;

    localparam logic [7:0] LINK_RST_VAL = 8'h80;

    localparam logic [7:0] CMD_START  = 8'hAA;
    localparam logic [7:0] CMD_HWCFG  = 8'h5A;
    localparam logic [7:0] CMD_PNPOFF = 8'h55;
    localparam logic [7:0] CMD_KEYOFF = 8'h56;
    localparam logic [7:0] END_CODE_A = 8'h00;
    localparam logic [7:0] END_CODE_B = 8'h40;

    localparam int IND_COUNT = 16;

    // Write mask applied to each indirect index; zero for discarded ones.
    function automatic logic [7:0] ind_mask(input logic [3:0] idx);
        case (idx)
            4'd2, 4'd6: ind_mask = 8'hFF;
            4'd3:       ind_mask = 8'hE0;
            4'd4:       ind_mask = 8'hF0;
            4'd5:       ind_mask = 8'hFE;
            4'd8:       ind_mask = 8'h0F;
            default:    ind_mask = 8'h00;
        endcase
    endfunction

    // Indices whose storage is updated by a write.
    function automatic logic ind_writable(input logic [3:0] idx);
        case (idx)
            4'd0, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd8: ind_writable = 1'b1;
            default:                                   ind_writable = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/ctlp_cfg_ram.sv
module ctlp_cfg_ram #(
    parameter int DEPTH  = 1024,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata
);

    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[addr] <= wdata;
        end
    end

    assign rdata = mem_q[addr];

endmodule

// File: rtl/ctlp_ind_bank.sv
module ctlp_ind_bank
    import ctlp_pkg::*;
#(
    parameter logic [7:0] CHIP_ID = 8'h5C
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [3:0] idx,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       codec_rst_o
);

    typedef struct packed {
        logic [IND_COUNT-1:0][7:0] regs;
        logic                      codec_rst;
    } ind_t;

    ind_t q, d;

    always_comb begin
        d = q;
        d.codec_rst = 1'b0;
        if (wr && ind_writable(idx)) begin
            d.regs[idx] = wdata & ind_mask(idx);
            if (idx == 4'd0) begin
                d.regs[0]   = 8'h00;
                d.codec_rst = wdata[7];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q         <= '0;
            q.regs[1] <= CHIP_ID;
        end else begin
            q <= d;
        end
    end

    assign rdata       = q.regs[idx];
    assign codec_rst_o = q.codec_rst;

endmodule

// File: rtl/ctlp_dl_seq.sv
module ctlp_dl_seq
    import ctlp_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              port_wr,
    input  logic              port_rd,
    input  logic              end_wr,
    input  logic [7:0]        wdata,
    output dl_phase_e         phase_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              ram_we_o,
    output logic              hwcfg_o,
    output logic              keyoff_o,
    output logic              done_o,
    output logic              pnp_en_o
);

    typedef struct packed {
        dl_phase_e         phase;
        logic [ADDR_W-1:0] addr;
        logic              hwcfg;
        logic              keyoff;
        logic              done;
        logic              pnp_en;
    } seq_t;

    seq_t q, d;
    logic [15:0] lo16, hi16, cur16;
    logic        end_ok;

    always_comb begin
        d        = q;
        d.hwcfg  = 1'b0;
        d.keyoff = 1'b0;
        d.done   = 1'b0;
        cur16    = 16'(q.addr);
        lo16     = {8'h00, wdata};
        hi16     = {wdata, cur16[7:0]};
        end_ok   = end_wr && ((wdata == END_CODE_A) || (wdata == END_CODE_B));
        if (end_ok) begin
            d.phase = PH_CMD;
            d.done  = 1'b1;
        end else if (port_wr) begin
            case (q.phase)
                PH_CMD: begin
                    case (wdata)
                        CMD_START:  d.phase = PH_ALO;
                        CMD_HWCFG:  d.hwcfg = 1'b1;
                        CMD_PNPOFF: begin
                            d.hwcfg  = 1'b1;
                            d.pnp_en = 1'b0;
                        end
                        CMD_KEYOFF: d.keyoff = 1'b1;
                        default: ;
                    endcase
                end
                PH_ALO: begin
                    d.addr  = lo16[ADDR_W-1:0];
                    d.phase = PH_AHI;
                end
                PH_AHI: begin
                    d.addr  = hi16[ADDR_W-1:0];
                    d.phase = PH_DATA;
                end
                default: d.addr = q.addr + ADDR_W'(1);
            endcase
        end else if (port_rd && (q.phase == PH_DATA)) begin
            d.addr = q.addr + ADDR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q        <= '0;
            q.phase  <= PH_CMD;
            q.pnp_en <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign phase_o  = q.phase;
    assign addr_o   = q.addr;
    assign ram_we_o = port_wr && (q.phase == PH_DATA);
    assign hwcfg_o  = q.hwcfg;
    assign keyoff_o = q.keyoff;
    assign done_o   = q.done;
    assign pnp_en_o = q.pnp_en;

endmodule

// File: rtl/audio_ctl_port.sv
module audio_ctl_port
    import ctlp_pkg::*;
#(
    parameter int         RAM_DEPTH = 1024,
    parameter logic [7:0] CHIP_ID   = 8'h5C
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] bus_addr,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       codec_reset_o,
    output logic       hwcfg_update_o,
    output logic       key_disable_o,
    output logic       dl_done_o,
    output logic       pnp_enable_o
);

    localparam int ADDR_W = $clog2(RAM_DEPTH);
    localparam int NUM_DIR = 8;

    typedef struct packed {
        logic [NUM_DIR-1:0][7:0] dir;
    } dir_t;

    dir_t q, d;

    dl_phase_e         phase;
    logic [ADDR_W-1:0] ram_addr;
    logic              ram_we;
    logic [7:0]        ram_rdata;
    logic [7:0]        ind_rdata;
    logic              ind_wr, port_wr, port_rd, end_wr;

    assign ind_wr  = bus_wr && (bus_addr == OFS_IDAT);
    assign port_wr = bus_wr && (bus_addr == OFS_DLPRT);
    assign port_rd = bus_rd && !bus_wr && (bus_addr == OFS_DLPRT);
    assign end_wr  = bus_wr && (bus_addr == OFS_DLEND);

    always_comb begin
        d = q;
        if (bus_wr) begin
            case (bus_addr)
                OFS_IDX:  d.dir[OFS_IDX] = {4'h0, bus_wdata[3:0]};
                OFS_STAT: ;
                default:  d.dir[bus_addr] = bus_wdata;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q              <= '0;
            q.dir[OFS_LINK] <= LINK_RST_VAL;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        case (bus_addr)
            OFS_IDAT:  bus_rdata = ind_rdata;
            OFS_DLPRT: bus_rdata = (phase == PH_DATA) ? ram_rdata : q.dir[OFS_DLPRT];
            default:   bus_rdata = q.dir[bus_addr];
        endcase
    end

    ctlp_ind_bank #(
        .CHIP_ID(CHIP_ID)
    ) u_ind (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (ind_wr),
        .idx        (q.dir[OFS_IDX][3:0]),
        .wdata      (bus_wdata),
        .rdata      (ind_rdata),
        .codec_rst_o(codec_reset_o)
    );

    ctlp_dl_seq #(
        .ADDR_W(ADDR_W)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .port_wr (port_wr),
        .port_rd (port_rd),
        .end_wr  (end_wr),
        .wdata   (bus_wdata),
        .phase_o (phase),
        .addr_o  (ram_addr),
        .ram_we_o(ram_we),
        .hwcfg_o (hwcfg_update_o),
        .keyoff_o(key_disable_o),
        .done_o  (dl_done_o),
        .pnp_en_o(pnp_enable_o)
    );

    ctlp_cfg_ram #(
        .DEPTH (RAM_DEPTH),
        .ADDR_W(ADDR_W)
    ) u_ram (
        .clk  (clk),
        .we   (ram_we),
        .addr (ram_addr),
        .wdata(bus_wdata),
        .rdata(ram_rdata)
    );

endmodule

// File: rtl/ctlp_checker.sv
module ctlp_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] bus_addr,
    input logic       bus_wr,
    input logic [7:0] bus_wdata,
    input logic       codec_reset_o,
    input logic       hwcfg_update_o,
    input logic       key_disable_o,
    input logic       dl_done_o,
    input logic       pnp_enable_o
);

    logic close_wr;
    assign close_wr = bus_wr && (bus_addr == 3'd6) &&
                      ((bus_wdata == 8'h00) || (bus_wdata == 8'h40));

    AST_CODEC_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        codec_reset_o |-> $past(bus_wr && (bus_addr == 3'd4) && bus_wdata[7])); // R4

    AST_HWCFG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        hwcfg_update_o |-> $past(bus_wr && (bus_addr == 3'd5) &&
                                 ((bus_wdata == 8'h5A) || (bus_wdata == 8'h55)))); // R5

    AST_KEY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        key_disable_o |-> $past(bus_wr && (bus_addr == 3'd5) && (bus_wdata == 8'h56))); // R5

    AST_PNP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !pnp_enable_o |=> !pnp_enable_o); // R5

    AST_PNP_WITH_HWCFG: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pnp_enable_o) |-> hwcfg_update_o); // R5

    AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        dl_done_o |-> $past(close_wr)); // R8

    AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        close_wr |=> dl_done_o); // R8

endmodule

bind audio_ctl_port ctlp_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_addr      (bus_addr),
    .bus_wr        (bus_wr),
    .bus_wdata     (bus_wdata),
    .codec_reset_o (codec_reset_o),
    .hwcfg_update_o(hwcfg_update_o),
    .key_disable_o (key_disable_o),
    .dl_done_o     (dl_done_o),
    .pnp_enable_o  (pnp_enable_o)
);

// File: tb/audio_ctl_port_tb.sv
`timescale 1ns/1ps
module audio_ctl_port_tb;

    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] TB_CHIP = 8'h5C;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       codec_reset_o, hwcfg_update_o, key_disable_o, dl_done_o, pnp_enable_o;

    int checks = 0;
    int fails = 0;
    bit finished = 0;
    logic [3:0] pulses;   // {codec, hwcfg, key, done} after last write

    audio_ctl_port #(.RAM_DEPTH(1024), .CHIP_ID(TB_CHIP)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .codec_reset_o(codec_reset_o),
        .hwcfg_update_o(hwcfg_update_o), .key_disable_o(key_disable_o),
        .dl_done_o(dl_done_o), .pnp_enable_o(pnp_enable_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%02h expected 0x%02h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        pulses = {codec_reset_o, hwcfg_update_o, key_disable_o, dl_done_o};
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rd_ind(input logic [3:0] i, output logic [7:0] v);
        wr(3'd3, {4'h0, i});
        rd(3'd4, v);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            check("R1", $sformatf("offset %0d", a), v, (a == 1) ? 8'h80 : 8'h00);
        end
        rd_ind(4'd1, v); check("R1", "chip id", v, TB_CHIP);
        rd_ind(4'd8, v); check("R1", "ind 8", v, 8'h00);
        check("R1", "pnp/pulses", {3'b0, pnp_enable_o, codec_reset_o, hwcfg_update_o, key_disable_o, dl_done_o}, 8'h10);
    endtask

    task automatic t_direct();
        logic [7:0] v;
        wr(3'd0, 8'hA5); rd(3'd0, v); check("R2", "offset 0", v, 8'hA5);
        wr(3'd2, 8'h3C); rd(3'd2, v); check("R2", "offset 2", v, 8'h3C);
        wr(3'd3, 8'hF7); rd(3'd3, v); check("R2", "offset 3 low nibble", v, 8'h07);
        wr(3'd7, 8'h33); rd(3'd7, v); check("R2", "offset 7 ignored", v, 8'h00);
    endtask

    task automatic t_indirect();
        logic [7:0] v;
        logic [7:0] exp [16] = '{8'h00, TB_CHIP, 8'hFF, 8'hE0, 8'hF0, 8'hFE, 8'hFF, 8'h00,
                                 8'h0F, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
        for (int i = 1; i < 16; i++) begin
            wr(3'd3, 8'(i));
            wr(3'd4, 8'hFF);
            rd(3'd4, v);
            check("R3", $sformatf("ind %0d masked", i), v, exp[i]);
        end
        wr(3'd3, 8'hF2); wr(3'd4, 8'h5A); rd(3'd4, v);
        check("R3", "index upper bits ignored", v, 8'h5A);
    endtask

    task automatic t_codec();
        logic [7:0] v;
        wr(3'd3, 8'h00);
        wr(3'd4, 8'h81);
        check("R4", "codec pulse on bit7", {4'h0, pulses}, 8'h08);
        rd(3'd4, v); check("R4", "ind 0 reads zero", v, 8'h00);
        check("R4", "pulse one cycle", {7'h0, codec_reset_o}, 8'h00);
        wr(3'd4, 8'h7F);
        check("R4", "no pulse without bit7", {4'h0, pulses}, 8'h00);
        rd(3'd4, v); check("R4", "ind 0 still zero", v, 8'h00);
    endtask

    task automatic t_commands();
        logic [7:0] v;
        wr(3'd5, 8'h5A); check("R5", "hwcfg cmd", {3'h0, pnp_enable_o, pulses}, 8'h14);
        wr(3'd5, 8'h56); check("R5", "key cmd", {3'h0, pnp_enable_o, pulses}, 8'h12);
        wr(3'd5, 8'h12); check("R5", "other cmd", {3'h0, pnp_enable_o, pulses}, 8'h10);
        wr(3'd5, 8'h34); check("R5", "other cmd 2", {4'h0, pulses}, 8'h00);
        rd(3'd5, v); check("R7", "offset 5 outside data", v, 8'h34);
        wr(3'd5, 8'h55); check("R5", "pnp off cmd", {3'h0, pnp_enable_o, pulses}, 8'h04);
        wr(3'd5, 8'h5A); check("R5", "pnp stays low", {7'h0, pnp_enable_o}, 8'h00);
    endtask

    task automatic t_download();
        logic [7:0] v;
        wr(3'd5, 8'hAA); wr(3'd5, 8'h10); wr(3'd5, 8'h02);
        wr(3'd5, 8'hC1); wr(3'd5, 8'hC2); wr(3'd5, 8'hC3);
        check("R6", "no pulses while storing", {4'h0, pulses}, 8'h00);
        wr(3'd6, 8'h00); check("R8", "done on 0x00", {4'h0, pulses}, 8'h01);
        wr(3'd5, 8'hAA); wr(3'd5, 8'h11); wr(3'd5, 8'h02);
        rd(3'd5, v); check("R7", "read 0x211", v, 8'hC2);
        rd(3'd5, v); check("R7", "read 0x212 post-inc", v, 8'hC3);
        wr(3'd6, 8'h01); check("R8", "bad close no pulse", {4'h0, pulses}, 8'h00);
        wr(3'd5, 8'hD4);
        wr(3'd6, 8'h40); check("R8", "done on 0x40", {4'h0, pulses}, 8'h01);
        wr(3'd5, 8'hAA); wr(3'd5, 8'h10); wr(3'd5, 8'h02);
        rd(3'd5, v); check("R6", "byte at 0x210", v, 8'hC1);
        rd(3'd5, v); rd(3'd5, v); rd(3'd5, v);
        check("R8", "phase kept after bad close", v, 8'hD4);
        wr(3'd6, 8'h00);
    endtask

    task automatic t_wrap();
        logic [7:0] v;
        wr(3'd5, 8'hAA); wr(3'd5, 8'hFF); wr(3'd5, 8'h03);
        wr(3'd5, 8'h11); wr(3'd5, 8'h22);
        wr(3'd6, 8'h00);
        wr(3'd5, 8'hAA); wr(3'd5, 8'h00); wr(3'd5, 8'h04);
        rd(3'd5, v); check("R9", "0x400 maps to 0", v, 8'h22);
        wr(3'd6, 8'h00);
        wr(3'd5, 8'hAA); wr(3'd5, 8'hFF); wr(3'd5, 8'h07);
        rd(3'd5, v); check("R9", "0x7FF maps to 0x3FF", v, 8'h11);
        rd(3'd5, v); check("R9", "increment wraps", v, 8'h22);
        wr(3'd6, 8'h00);
    endtask

    task automatic t_codes_as_data();
        logic [7:0] v;
        wr(3'd5, 8'hAA); wr(3'd5, 8'h55);
        check("R10", "0x55 as low byte", {4'h0, pulses}, 8'h00);
        wr(3'd5, 8'h00);
        wr(3'd5, 8'h56); check("R10", "0x56 as data", {4'h0, pulses}, 8'h00);
        wr(3'd5, 8'h5A); check("R10", "0x5A as data", {4'h0, pulses}, 8'h00);
        wr(3'd5, 8'hAA);
        wr(3'd6, 8'h00);
        wr(3'd5, 8'hAA); wr(3'd5, 8'h55); wr(3'd5, 8'h00);
        rd(3'd5, v); check("R10", "stored 0x56", v, 8'h56);
        rd(3'd5, v); check("R10", "stored 0x5A", v, 8'h5A);
        rd(3'd5, v); check("R10", "stored 0xAA", v, 8'hAA);
        wr(3'd6, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_direct();
        t_indirect();
        t_codec();
        t_commands();
        t_download();
        t_wrap();
        t_codes_as_data();
        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule